// File: doc/BRIEF.md
# Strided Burst Walker

The strided burst walker turns a small descriptor of access patterns into a stream of memory burst requests for a scatter/gather data mover. Each descriptor slot holds a region key, a 64-bit start pointer, an element size in bytes, a byte step between elements and a repeat count. Once started, the block walks the slots in index order and, for each slot, emits one burst per element. The consumer sees every burst tagged with a running logical offset, so the scattered pieces read back as a single contiguous byte stream.

Several patterns, each possibly under a different region key, are therefore joined into one logical region. A plain contiguous buffer is simply a slot with a repeat count of one, whose step value is then irrelevant. Slots are written through a simple write port before the walk is started. The block does not read memory, validate keys or translate pages: it only produces addresses.

The control is a three-state machine. IDLE accepts slot writes and the start request (transition IDLE→SCAN on `go`). SCAN inspects the slot under the cursor: it returns to IDLE when the cursor has passed the requested slot count (SCAN→IDLE), steps over a slot with nothing to emit (SCAN→SCAN), or enters EMIT with the first element of a slot that does emit (SCAN→EMIT). EMIT presents one burst and moves on at each accepted handshake: to the next element (EMIT→EMIT), to the next slot (EMIT→SCAN), or straight to IDLE when the accepted burst was the final one of the walk (EMIT→IDLE).

Top module: `strided_burst_walker`

## Requirements
- R1: After reset, `busy` and `bst_valid` are low.
- R2: Slots 0 to `go_count`-1 are walked in ascending index order; within a slot, element i (i = 0 up to repeat-1, in ascending order) produces one burst with `bst_key` equal to the slot key, `bst_addr` equal to start + i × step, and `bst_len` equal to the element size.
- R3: A slot with repeat count 1 produces exactly one burst at its start pointer, whatever its step value.
- R4: A slot whose repeat count is 0 or whose element size is 0 produces no burst; `bst_len` is never 0 while `bst_valid` is high.
- R5: `bst_offset` is 0 on the first burst of a walk and, on every later burst, equals the sum of `bst_len` over all bursts accepted earlier in that walk.
- R6: `bst_last` is high on exactly one burst per walk: the final element of the highest-numbered emitting slot; after that burst is accepted, `busy` is low on the next cycle.
- R7: While `busy` is high, slot writes (`cfg_we`) and start requests (`go`) are ignored; a later walk uses the slot contents written before the busy period.
- R8: While `bst_valid` is high and `bst_ready` is low, `bst_valid` stays high and all burst fields stay unchanged on the next cycle.
- R9: A walk with `go_count` = 0, or with no emitting slot among the requested ones, emits no burst and drops `busy` again by itself.
- R10: Addresses are computed modulo 2^64: start + i × step carries across bit 31 and wraps past the top of the address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Slot write strobe, taken only while idle |
| cfg_idx | input | 3 | Slot index to write |
| cfg_key | input | 32 | Region key of the slot |
| cfg_base | input | 64 | Start pointer of the slot |
| cfg_len | input | 32 | Element size in bytes |
| cfg_stride | input | 32 | Byte step between element starts |
| cfg_rep | input | 16 | Number of elements |
| go | input | 1 | Start a walk, taken only while idle |
| go_count | input | 4 | Number of slots to walk, from slot 0 |
| busy | output | 1 | A walk is in progress |
| bst_valid | output | 1 | A burst request is presented |
| bst_ready | input | 1 | Consumer accepts the burst |
| bst_key | output | 32 | Region key of the burst |
| bst_addr | output | 64 | Start address of the burst |
| bst_len | output | 32 | Burst length in bytes |
| bst_offset | output | 64 | Logical offset of the burst in the joined stream |
| bst_last | output | 1 | Final burst of the walk |

## Verification
The two functions that meet in one cycle are burst emission and descriptor loading: a slot write and a new start request can arrive on the very edge where the walker hands over a burst, or while it sits stalled on backpressure. The bench provokes this by driving `cfg_we` and `go` into slot 0 three cycles into a long walk under a pseudo-random ready pattern, then runs the same descriptor again; the scoreboard judges it by requiring both walks to produce the bursts computed from the original slot contents, with no extra walk started. The same random ready pattern also makes stalls coincide with slot boundaries, where the offset and the last flag must survive the hold.

// File: rtl/sbw_pkg.sv
package sbw_pkg;

    parameter int KEY_W  = 32;
    parameter int ADDR_W = 64;
    parameter int LEN_W  = 32;
    parameter int REP_W  = 16;

    typedef struct packed {
        logic [KEY_W-1:0]  key;
        logic [ADDR_W-1:0] base;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  stride;
        logic [REP_W-1:0]  rep;
    } sbw_slot_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_EMIT = 2'd2
    } sbw_state_t;

endpackage

// File: rtl/sbw_slot_store.sv
module sbw_slot_store
    import sbw_pkg::*;
#(
    parameter int SLOTS = 8,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  sbw_slot_t        wdata,
    input  logic [IDX_W-1:0] ridx,
    output sbw_slot_t        rdata,
    output logic [SLOTS-1:0] live
);

    sbw_slot_t slot_q [SLOTS];

    for (genvar j = 0; j < SLOTS; j++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[j] <= '0;
            end else if (we && (widx == IDX_W'(j))) begin
                slot_q[j] <= wdata;
            end
        end

        // a slot emits only with a nonzero size and a nonzero count
        assign live[j] = (slot_q[j].len != '0) && (slot_q[j].rep != '0);
    end

    assign rdata = slot_q[ridx];

endmodule

// File: rtl/sbw_tail_scan.sv
module sbw_tail_scan #(
    parameter int SLOTS = 8,
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic [SLOTS-1:0] live,
    input  logic [CNT_W-1:0] cur,
    input  logic [CNT_W-1:0] count,
    output logic             more
);

    logic [SLOTS-1:0] ahead;

    for (genvar j = 0; j < SLOTS; j++) begin : g_ahead
        assign ahead[j] = live[j] && (CNT_W'(j) > cur) && (CNT_W'(j) < count);
    end

    assign more = |ahead;

endmodule

// File: rtl/strided_burst_walker.sv
module strided_burst_walker
    import sbw_pkg::*;
#(
    parameter int SLOTS = 8,
    localparam int IDX_W = $clog2(SLOTS),
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [KEY_W-1:0]  cfg_key,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [LEN_W-1:0]  cfg_stride,
    input  logic [REP_W-1:0]  cfg_rep,
    input  logic              go,
    input  logic [CNT_W-1:0]  go_count,
    output logic              busy,
    output logic              bst_valid,
    input  logic              bst_ready,
    output logic [KEY_W-1:0]  bst_key,
    output logic [ADDR_W-1:0] bst_addr,
    output logic [LEN_W-1:0]  bst_len,
    output logic [ADDR_W-1:0] bst_offset,
    output logic              bst_last
);

    sbw_state_t       state_q, state_d;
    logic [CNT_W-1:0] cur_q;
    logic [CNT_W-1:0] cnt_q;
    logic [REP_W-1:0] elem_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] off_q;

    sbw_slot_t        cur_slot;
    sbw_slot_t        wr_slot;
    logic [SLOTS-1:0] live;
    logic             more;
    logic             in_range;
    logic             final_elem;
    logic             take;
    logic             wr_ok;

    assign wr_ok   = cfg_we && (state_q == ST_IDLE);
    assign wr_slot = '{key: cfg_key, base: cfg_base, len: cfg_len,
                       stride: cfg_stride, rep: cfg_rep};

    sbw_slot_store #(.SLOTS(SLOTS)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_ok),
        .widx  (cfg_idx),
        .wdata (wr_slot),
        .ridx  (cur_q[IDX_W-1:0]),
        .rdata (cur_slot),
        .live  (live)
    );

    sbw_tail_scan #(.SLOTS(SLOTS)) u_tail (
        .live  (live),
        .cur   (cur_q),
        .count (cnt_q),
        .more  (more)
    );

    assign in_range   = (cur_q < cnt_q) && (cur_q < CNT_W'(SLOTS));
    assign final_elem = (elem_q == cur_slot.rep - REP_W'(1));
    assign take       = (state_q == ST_EMIT) && bst_ready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go) begin
                    state_d = ST_SCAN;
                end
            end
            ST_SCAN: begin
                if (!in_range) begin
                    state_d = ST_IDLE;
                end else if (live[cur_q[IDX_W-1:0]]) begin
                    state_d = ST_EMIT;
                end
            end
            ST_EMIT: begin
                if (take && final_elem) begin
                    state_d = more ? ST_SCAN : ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q  <= '0;
            cnt_q  <= '0;
            elem_q <= '0;
            addr_q <= '0;
            off_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (go) begin
                        cur_q <= '0;
                        cnt_q <= go_count;
                        off_q <= '0;
                    end
                end
                ST_SCAN: begin
                    if (in_range) begin
                        if (live[cur_q[IDX_W-1:0]]) begin
                            elem_q <= '0;
                            addr_q <= cur_slot.base;
                        end else begin
                            cur_q <= cur_q + CNT_W'(1);
                        end
                    end
                end
                ST_EMIT: begin
                    if (take) begin
                        off_q <= off_q + ADDR_W'(cur_slot.len);
                        if (final_elem) begin
                            cur_q <= cur_q + CNT_W'(1);
                        end else begin
                            elem_q <= elem_q + REP_W'(1);
                            addr_q <= addr_q + ADDR_W'(cur_slot.stride);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy       = (state_q != ST_IDLE);
        bst_valid  = (state_q == ST_EMIT);
        bst_key    = cur_slot.key;
        bst_addr   = addr_q;
        bst_len    = cur_slot.len;
        bst_offset = off_q;
        bst_last   = (state_q == ST_EMIT) && final_elem && !more;
    end

endmodule

// File: rtl/sbw_checker.sv
module sbw_checker
    import sbw_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              bst_valid,
    input logic              bst_ready,
    input logic [KEY_W-1:0]  bst_key,
    input logic [ADDR_W-1:0] bst_addr,
    input logic [LEN_W-1:0]  bst_len,
    input logic [ADDR_W-1:0] bst_offset,
    input logic              bst_last
);

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) == 1'b0) |-> (!busy && !bst_valid));

    assert_no_empty_burst_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bst_valid |-> (bst_len != '0));

    assert_offset_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bst_valid && bst_ready) |=> (bst_offset == $past(bst_offset) + ADDR_W'($past(bst_len))));

    assert_last_ends_walk_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bst_valid && bst_ready && bst_last) |=> !busy);

    assert_hold_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bst_valid && !bst_ready) |=> (bst_valid && $stable(bst_key) && $stable(bst_addr)
            && $stable(bst_len) && $stable(bst_offset) && $stable(bst_last)));

endmodule

bind strided_burst_walker sbw_checker u_sbw_checker (.*);

// File: tb/test_strided_burst_walker.sv
module test_strided_burst_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_key = '0;
    logic [63:0] cfg_base = '0;
    logic [31:0] cfg_len = '0;
    logic [31:0] cfg_stride = '0;
    logic [15:0] cfg_rep = '0;
    logic        go = 1'b0;
    logic [3:0]  go_count = '0;
    logic        busy;
    logic        bst_valid;
    logic        bst_ready;
    logic [31:0] bst_key;
    logic [63:0] bst_addr;
    logic [31:0] bst_len;
    logic [63:0] bst_offset;
    logic        bst_last;

    always #10 clk = ~clk;

    strided_burst_walker i_strided_burst_walker (.*);

    typedef struct {
        logic [31:0] key;
        logic [63:0] addr;
        logic [31:0] len;
        logic [63:0] off;
        logic        last;
    } exp_t;

    exp_t  sb_q[$];
    int    n_checks = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    logic  wd_hit = 1'b0;
    int    cycles = 0;

    logic [31:0] m_key[8];
    logic [63:0] m_base[8];
    logic [31:0] m_len[8];
    logic [31:0] m_stride[8];
    logic [15:0] m_rep[8];

    logic [15:0] lfsr = 16'hACE1;
    logic        rdy_force = 1'b0;
    assign bst_ready = rdy_force | lfsr[0] | lfsr[3];

    always @(posedge clk) begin
        #2;
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // monitor: scoreboard pop plus stall-hold tracking
    logic        stalled = 1'b0;
    exp_t        held;
    always @(negedge clk) begin
        if (rst_n) begin
            if (stalled) begin
                chk(bst_valid && bst_key == held.key && bst_addr == held.addr &&
                    bst_len == held.len && bst_offset == held.off && bst_last == held.last,
                    "R8", "held burst addr", bst_addr, held.addr);
            end
            stalled = bst_valid && !bst_ready;
            held = '{key: bst_key, addr: bst_addr, len: bst_len, off: bst_offset, last: bst_last};
            if (bst_valid && bst_ready) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, cur_req, "unexpected burst addr", bst_addr, 64'h0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(bst_key == e.key, {cur_req, " R2"}, "key", 64'(bst_key), 64'(e.key));
                    chk(bst_addr == e.addr, {cur_req, " R2"}, "addr", bst_addr, e.addr);
                    chk(bst_len == e.len, {cur_req, " R2"}, "len", 64'(bst_len), 64'(e.len));
                    chk(bst_offset == e.off, {cur_req, " R5"}, "offset", bst_offset, e.off);
                    chk(bst_last == e.last, {cur_req, " R6"}, "last", 64'(bst_last), 64'(e.last));
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !wd_hit) begin
            wd_hit = 1'b1;
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    task automatic put_slot(input int idx, input logic [31:0] k, input logic [63:0] b,
                            input logic [31:0] l, input logic [31:0] s, input logic [15:0] r);
        @(posedge clk); #2;
        cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_key = k; cfg_base = b;
        cfg_len = l; cfg_stride = s; cfg_rep = r;
        m_key[idx] = k; m_base[idx] = b; m_len[idx] = l; m_stride[idx] = s; m_rep[idx] = r;
        @(posedge clk); #2;
        cfg_we = 1'b0;
    endtask

    task automatic push_expected(input int cnt);
        int          lastj = -1;
        logic [63:0] off = '0;
        for (int j = 0; j < cnt && j < 8; j++) begin
            if (m_len[j] != 0 && m_rep[j] != 0) lastj = j;
        end
        for (int j = 0; j < cnt && j < 8; j++) begin
            if (m_len[j] != 0 && m_rep[j] != 0) begin
                for (int i = 0; i < int'(m_rep[j]); i++) begin
                    exp_t e;
                    e.key  = m_key[j];
                    e.addr = m_base[j] + 64'(i) * 64'(m_stride[j]);
                    e.len  = m_len[j];
                    e.off  = off;
                    e.last = (j == lastj) && (i == int'(m_rep[j]) - 1);
                    off    = off + 64'(m_len[j]);
                    sb_q.push_back(e);
                end
            end
        end
    endtask

    task automatic wait_done(input string req);
        while (busy && !wd_hit) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(!busy, req, "busy after walk", 64'(busy), 64'h0);
        chk(sb_q.size() == 0, req, "bursts outstanding", 64'(sb_q.size()), 64'h0);
    endtask

    task automatic run_walk(input int cnt, input string req, input bit poke);
        cur_req = req;
        push_expected(cnt);
        @(posedge clk); #2;
        go = 1'b1; go_count = 4'(cnt);
        @(posedge clk); #2;
        go = 1'b0;
        if (poke) begin
            repeat (2) @(posedge clk);
            #2;
            chk(busy, "R7", "busy during walk", 64'(busy), 64'h1);
            // write and start attempted together while the walk runs
            cfg_we = 1'b1; cfg_idx = 3'd0; cfg_key = 32'h99; cfg_base = 64'hBAD0;
            cfg_len = 32'd1; cfg_stride = 32'd1; cfg_rep = 16'd1;
            go = 1'b1; go_count = 4'd2;
            @(posedge clk); #2;
            cfg_we = 1'b0; go = 1'b0;
        end
        wait_done(req);
    endtask

    initial begin
        for (int j = 0; j < 8; j++) begin
            m_key[j] = '0; m_base[j] = '0; m_len[j] = '0; m_stride[j] = '0; m_rep[j] = '0;
        end
        repeat (3) @(posedge clk);
        #2;
        chk(!busy, "R1", "busy in reset", 64'(busy), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !bst_valid, "R1", "idle after reset", 64'({busy, bst_valid}), 64'h0);

        // R3: contiguous slot, step value irrelevant
        put_slot(0, 32'h11, 64'h1000, 32'd64, 32'hDEAD_BEEF, 16'd1);
        run_walk(1, "R3", 1'b0);

        // R2, R5: three slots under different keys
        put_slot(0, 32'hA1, 64'h2000, 32'd16, 32'h40, 16'd3);
        put_slot(1, 32'hB2, 64'h8000, 32'd8, 32'h0, 16'd1);
        put_slot(2, 32'hC3, 64'h3000, 32'd4, 32'h100, 16'd2);
        run_walk(3, "R2", 1'b0);

        // R4, R6: skipped slots in the middle and at the tail
        put_slot(0, 32'h21, 64'h100, 32'd12, 32'h20, 16'd2);
        put_slot(1, 32'h22, 64'h500, 32'd0, 32'h10, 16'd4);
        put_slot(2, 32'h23, 64'h900, 32'd5, 32'd7, 16'd3);
        put_slot(3, 32'h24, 64'hA00, 32'd9, 32'd9, 16'd0);
        put_slot(4, 32'h25, 64'hB00, 32'd0, 32'd0, 16'd0);
        run_walk(5, "R4", 1'b0);

        // R7: write and start while busy are ignored, then the same walk again
        put_slot(0, 32'h31, 64'h4000, 32'd32, 32'h80, 16'd6);
        run_walk(1, "R7", 1'b1);
        run_walk(1, "R7", 1'b0);

        // R9: zero count, then only empty slots
        run_walk(0, "R9", 1'b0);
        put_slot(0, 32'h41, 64'h10, 32'd0, 32'd4, 16'd3);
        put_slot(1, 32'h42, 64'h20, 32'd4, 32'd4, 16'd0);
        run_walk(2, "R9", 1'b0);

        // R10: carries across bit 31 and wrap past the top
        put_slot(0, 32'h51, 64'h0000_0000_FFFF_FFF0, 32'd8, 32'h20, 16'd3);
        put_slot(1, 32'h52, 64'hFFFF_FFFF_FFFF_FFF0, 32'd16, 32'h10, 16'd2);
        run_walk(2, "R10", 1'b0);

        // R2: all eight slots, back-to-back acceptance
        for (int j = 0; j < 8; j++) begin
            put_slot(j, 32'h60 + 32'(j), 64'h1_0000 + 64'(j) * 64'h1000,
                     32'(j + 1), 32'h40, 16'((j % 2) + 1));
        end
        rdy_force = 1'b1;
        run_walk(8, "R2", 1'b0);
        rdy_force = 1'b0;
        run_walk(8, "R8", 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule